// File: doc/BRIEF.md
# Differential Key Byte Recovery Engine

This block recovers one last-round key byte of an AES-128 encryption from repeated fault experiments on a single byte position. Each experiment gives a pair of bytes at that position: the good ciphertext byte C and the faulted ciphertext byte D. The fault is assumed to have flipped one bit, or two bits in two-bit mode, of the state byte M just before the final S-box. For each pair the engine scans all 256 values of M. Every M that fits the fault hypothesis adds the key byte C XOR S(M) to a 256-bit candidate bitmap. The S-box S is the AES S-box: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 0x63.

The candidate sets from successive pairs are folded into a running set. The first set after reset or clear is taken as it is. A later set narrows the running set by intersection. If that intersection would be empty, the later set is added by union instead, which tolerates a pair whose fault did not match the hypothesis. When the running set holds exactly one member, the engine stops and presents that key byte. It then ignores further pairs until it is cleared.

The controller is a four-state machine:
- ST_IDLE waits for a pair and moves to ST_SCAN when it accepts one.
- ST_SCAN walks M from 0 to 255, one value per clock, and moves to ST_MERGE after M = 255.
- ST_MERGE folds the new set into the running set in one cycle. It moves to ST_DONE when the result has exactly one member, and back to ST_IDLE otherwise.
- ST_DONE holds the result.

Clear returns every state to ST_IDLE.

Top module: `kbr_engine`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `busy`=0, `cand_count`=0, `key_found`=0 and `key_byte`=0. `clr` takes precedence over `pair_valid`.
- R2: A pair offered with `pair_valid`=1 while idle and not found is captured. `busy` then reads 1 for exactly 257 cycles: 256 scan cycles and one merge cycle. Results are valid once `busy` falls.
- R3: With `two_bit_mode`=0, the candidate set holds K = C XOR S(M) for every M such that S(M) XOR S(M XOR e) = C XOR D for some e in {0x01,0x02,...,0x80}.
- R4: With `two_bit_mode`=1, the same rule applies, with e ranging over the 28 bytes that have exactly two bits set.
- R5: The first candidate set after reset or clear becomes the running set unchanged, even when it is empty.
- R6: When the running set and the new set share at least one member, the running set becomes their intersection.
- R7: When the running set and the new set share no member, the running set becomes their union.
- R8: `cand_count` equals the number of members of the running set.
- R9: When the running set has exactly one member, `key_found`=1 and `key_byte` is that member (bit index in the bitmap). Otherwise `key_byte`=0.
- R10: A pair offered while `busy`=1 or while `key_found`=1 is ignored: the running set, `key_found` and `key_byte` do not change.
- R11: `clr` during a scan aborts it. No merge happens, and the next pair is treated as a first set.
- R12: A pair with C = D yields an empty candidate set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of running set and controller |
| pair_valid | input | 1 | Strobe: a byte pair is offered this cycle |
| pair_good | input | 8 | Correct ciphertext byte C |
| pair_bad | input | 8 | Faulted ciphertext byte D |
| two_bit_mode | input | 1 | 0: one-bit fault hypothesis, 1: two-bit fault hypothesis |
| busy | output | 1 | Scan or merge in progress |
| cand_count | output | 9 | Number of members in the running set (0 to 256) |
| key_found | output | 1 | Running set holds exactly one member |
| key_byte | output | 8 | Recovered key byte when found, else 0 |

## Verification
The assertions assume the following about the inputs:
- Pairs arrive only as single-cycle strobes.
- A pair offered during a scan or after a result is meant to be dropped. The checks only require that such a pair leaves the captured bytes and the result unchanged.
- `clr` may arrive at any time, so every merge property excludes a cycle with a clear.

The stimulus follows these assumptions:
- Random campaigns build pairs from a hidden key K and a random state byte as C = S(M) XOR K and D = S(M XOR e) XOR K, with e of the weight the mode expects. The true key is therefore in every set.
- Directed cases cover the remaining paths: equal bytes, two sets searched to be disjoint so that the union path is taken, strobes inside a scan and after a result, and a clear in mid-scan.

// File: rtl/kbr_pkg.sv
package kbr_pkg;
    localparam int BYTE_W = 8;
    localparam int SET_W  = 1 << BYTE_W;
    localparam int CNT_W  = BYTE_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SET_W-1:0]  set_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_MERGE = 2'd2,
        ST_DONE  = 2'd3
    } ctrl_state_e;

    // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t aa;
        byte_t bb;
        logic  hi;
        acc = '0;
        aa  = a;
        bb  = b;
        for (int k = 0; k < BYTE_W; k++) begin
            if (bb[0]) acc = acc ^ aa;
            hi = aa[BYTE_W-1];
            aa = aa << 1;
            if (hi) aa = aa ^ 8'h1b;
            bb = bb >> 1;
        end
        return acc;
    endfunction

    // inverse as x^254, then affine map
    function automatic byte_t sbox(byte_t x);
        byte_t pw;
        byte_t inv;
        pw  = x;
        inv = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            pw  = gf_mul(pw, pw);
            inv = gf_mul(inv, pw);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [CNT_W-1:0] popcount(set_t s);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int k = 0; k < SET_W; k++) n = n + CNT_W'(s[k]);
        return n;
    endfunction
endpackage

// File: rtl/kbr_cand_gen.sv
module kbr_cand_gen
    import kbr_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          scan_en,
    input  logic [BW-1:0] m_idx,
    input  logic [BW-1:0] c_byte,
    input  logic [BW-1:0] d_byte,
    input  logic          two_bit,
    output set_t          cand_set
);
    localparam int NSLOT = BW * BW;

    logic [BW-1:0]    diff;
    logic [BW-1:0]    s_m;
    logic [BW-1:0]    key_idx;
    logic [NSLOT-1:0] hit;
    logic             any_hit;

    assign diff    = c_byte ^ d_byte;
    assign s_m     = sbox(m_idx);
    assign key_idx = c_byte ^ s_m;

    // one comparator per fault value: diagonal = single bit, upper = bit pair
    for (genvar gi = 0; gi < BW; gi++) begin : g_row
        for (genvar gj = 0; gj < BW; gj++) begin : g_col
            localparam logic [BW-1:0] FAULT = (BW'(1) << gi) | (BW'(1) << gj);
            if (gj == gi) begin : g_one
                assign hit[gi*BW+gj] = !two_bit && ((s_m ^ sbox(m_idx ^ FAULT)) == diff);
            end else if (gj > gi) begin : g_two
                assign hit[gi*BW+gj] = two_bit && ((s_m ^ sbox(m_idx ^ FAULT)) == diff);
            end else begin : g_none
                assign hit[gi*BW+gj] = 1'b0;
            end
        end
    end

    assign any_hit = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_set <= '0;
        end else if (start) begin
            cand_set <= '0;
        end else if (scan_en && any_hit) begin
            cand_set[key_idx] <= 1'b1;
        end
    end

    // R3: a scan only ever adds members to the set under construction
    assert_scan_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> ($countones(cand_set) >= $countones($past(cand_set))));
endmodule

// File: rtl/kbr_merge.sv
module kbr_merge
    import kbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             merge_en,
    input  set_t             cand_set,
    output logic [CNT_W-1:0] count,
    output logic             next_single,
    output byte_t            key_idx
);
    set_t set_q;
    logic have_q;
    set_t next_set;
    set_t overlap;

    assign overlap = set_q & cand_set;

    always_comb begin
        if (!have_q)              next_set = cand_set;
        else if (overlap == '0)   next_set = set_q | cand_set;
        else                      next_set = overlap;
    end

    assign next_single = (popcount(next_set) == CNT_W'(1));
    assign count       = popcount(set_q);

    always_comb begin
        key_idx = '0;
        for (int k = 0; k < SET_W; k++) begin
            if (set_q[k]) key_idx = byte_t'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q  <= '0;
            have_q <= 1'b0;
        end else if (clr) begin
            set_q  <= '0;
            have_q <= 1'b0;
        end else if (merge_en) begin
            set_q  <= next_set;
            have_q <= 1'b1;
        end
    end

    // R6: a merge with common members never grows the running set
    assert_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_en && !clr && have_q && (overlap != '0)) |=> (count <= $past(count)));

    // R7: a merge with no common member keeps every old member
    assert_union_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_en && !clr && have_q && (overlap == '0)) |=> ((set_q & $past(set_q)) == $past(set_q)));
endmodule

// File: rtl/kbr_ctrl.sv
module kbr_ctrl
    import kbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  pair_valid,
    input  byte_t pair_good,
    input  byte_t pair_bad,
    input  logic  two_bit_mode,
    input  logic  next_single,
    output logic  start,
    output logic  scan_en,
    output logic  merge_en,
    output byte_t m_idx,
    output byte_t c_q,
    output byte_t d_q,
    output logic  mode_q,
    output logic  busy,
    output logic  found
);
    localparam byte_t M_LAST = '1;

    ctrl_state_e state_q;
    ctrl_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (pair_valid)      state_d = ST_SCAN;
                ST_SCAN:  if (m_idx == M_LAST) state_d = ST_MERGE;
                ST_MERGE: state_d = next_single ? ST_DONE : ST_IDLE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        start    = 1'b0;
        scan_en  = 1'b0;
        merge_en = 1'b0;
        busy     = 1'b0;
        found    = 1'b0;
        unique case (state_q)
            ST_IDLE:  start = pair_valid && !clr;
            ST_SCAN:  begin scan_en = 1'b1; busy = 1'b1; end
            ST_MERGE: begin merge_en = 1'b1; busy = 1'b1; end
            ST_DONE:  found = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx  <= '0;
            c_q    <= '0;
            d_q    <= '0;
            mode_q <= 1'b0;
        end else if (start) begin
            m_idx  <= '0;
            c_q    <= pair_good;
            d_q    <= pair_bad;
            mode_q <= two_bit_mode;
        end else if (scan_en) begin
            m_idx  <= m_idx + byte_t'(1);
        end
    end

    // R2: a scan runs on until its last value unless cleared
    assert_scan_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && m_idx != M_LAST && !clr) |=> (state_q == ST_SCAN));

    // R10: captured pair is stable while a scan is running
    assert_pair_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> ($stable(c_q) && $stable(d_q) && $stable(mode_q)));
endmodule

// File: rtl/kbr_engine.sv
module kbr_engine
    import kbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pair_valid,
    input  logic [7:0]       pair_good,
    input  logic [7:0]       pair_bad,
    input  logic             two_bit_mode,
    output logic             busy,
    output logic [CNT_W-1:0] cand_count,
    output logic             key_found,
    output logic [7:0]       key_byte
);
    logic  start;
    logic  scan_en;
    logic  merge_en;
    logic  next_single;
    logic  mode_q;
    byte_t m_idx;
    byte_t c_q;
    byte_t d_q;
    byte_t key_idx;
    set_t  cand_set;

    kbr_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .pair_valid   (pair_valid),
        .pair_good    (pair_good),
        .pair_bad     (pair_bad),
        .two_bit_mode (two_bit_mode),
        .next_single  (next_single),
        .start        (start),
        .scan_en      (scan_en),
        .merge_en     (merge_en),
        .m_idx        (m_idx),
        .c_q          (c_q),
        .d_q          (d_q),
        .mode_q       (mode_q),
        .busy         (busy),
        .found        (key_found)
    );

    kbr_cand_gen #(.BW(BYTE_W)) u_cand (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .scan_en  (scan_en),
        .m_idx    (m_idx),
        .c_byte   (c_q),
        .d_byte   (d_q),
        .two_bit  (mode_q),
        .cand_set (cand_set)
    );

    kbr_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .merge_en    (merge_en),
        .cand_set    (cand_set),
        .count       (cand_count),
        .next_single (next_single),
        .key_idx     (key_idx)
    );

    assign key_byte = key_found ? key_idx : 8'h00;

    // R9: found only with a single candidate
    assert_found_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        key_found |-> (cand_count == CNT_W'(1)));

    // R10: a found result is held until cleared
    assert_found_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_found && !clr) |=> (key_found && $stable(key_byte) && !busy));
endmodule

// File: tb/sim_kbr_engine.sv
module sim_kbr_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       pair_valid = 1'b0;
    logic [7:0] pair_good = '0;
    logic [7:0] pair_bad = '0;
    logic       two_bit_mode = 1'b0;
    logic       busy;
    logic [8:0] cand_count;
    logic       key_found;
    logic [7:0] key_byte;

    int checks = 0;
    int errors = 0;

    logic [7:0]   sb [256];
    logic [255:0] mset;
    logic         mhave;
    logic         mfound;

    always #4 clk = ~clk;

    kbr_engine u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pair_valid(pair_valid),
        .pair_good(pair_good), .pair_bad(pair_bad), .two_bit_mode(two_bit_mode),
        .busy(busy), .cand_count(cand_count), .key_found(key_found), .key_byte(key_byte)
    );

    function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
        end
        return r;
    endfunction

    function automatic int tb_pop(logic [255:0] s);
        int n = 0;
        for (int i = 0; i < 256; i++) n += s[i];
        return n;
    endfunction

    function automatic int tb_w8(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    function automatic logic [255:0] ref_set(logic [7:0] c, logic [7:0] d, logic two);
        logic [255:0] s = '0;
        for (int m = 0; m < 256; m++)
            for (int e = 1; e < 256; e++)
                if (tb_w8(e[7:0]) == (two ? 2 : 1))
                    if ((sb[m] ^ sb[m ^ e]) == (c ^ d)) s[c ^ sb[m]] = 1'b1;
        return s;
    endfunction

    function automatic logic [7:0] tb_member(logic [255:0] s);
        for (int i = 0; i < 256; i++) if (s[i]) return i[7:0];
        return 8'h00;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        chk({req, " R8 count"}, cand_count, tb_pop(mset));
        chk({req, " R9 found"}, key_found, mfound);
        chk({req, " R9 key"}, key_byte, mfound ? tb_member(mset) : 0);
    endtask

    task automatic model_merge(logic [255:0] e);
        if (!mhave)              mset = e;
        else if ((mset & e) == 0) mset = mset | e;
        else                     mset = mset & e;
        mhave  = 1'b1;
        mfound = (tb_pop(mset) == 1);
    endtask

    // send one pair; optional junk strobe in mid-scan; returns busy length
    task automatic send_pair(logic [7:0] c, logic [7:0] d, logic two, logic junk, output int nb);
        logic accept;
        accept = !mfound;
        @(negedge clk);
        pair_valid = 1'b1; pair_good = c; pair_bad = d; two_bit_mode = two;
        @(negedge clk);
        pair_valid = 1'b0;
        nb = 0;
        while (busy) begin
            nb++;
            if (junk && nb == 10) begin
                pair_valid = 1'b1; pair_good = ~c; pair_bad = c; two_bit_mode = ~two;
            end else begin
                pair_valid = 1'b0;
            end
            @(negedge clk);
        end
        pair_valid = 1'b0;
        if (accept) model_merge(ref_set(c, d, two));
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        mset = '0; mhave = 1'b0; mfound = 1'b0;
    endtask

    task automatic campaign(logic two, logic [7:0] key, string req);
        int nb;
        logic [7:0] m, e;
        for (int p = 0; p < 14 && !mfound; p++) begin
            m = $urandom_range(0, 255);
            do e = $urandom_range(1, 255); while (tb_w8(e) != (two ? 2 : 1));
            send_pair(sb[m] ^ key, sb[m ^ e] ^ key, two, 1'b0, nb);
            check_outputs(req);
        end
        if (mfound) chk({req, " R9 key equals secret"}, key_byte, key);
    endtask

    initial begin
        int nb;
        logic [255:0] s1, s2;
        logic [7:0] c1, d1, c2, d2;
        void'($urandom(1234));
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            for (int y = 1; y < 256; y++) if (tb_mul(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
            sb[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                        ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
        mset = '0; mhave = 0; mfound = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        check_outputs("R1 reset");

        // R12 / R5: equal bytes give empty first set
        send_pair(8'h5a, 8'h5a, 1'b0, 1'b0, nb);
        chk("R2 busy length", nb, 257);
        chk("R12 empty set", cand_count, 0);
        check_outputs("R5 R12");
        do_clear();

        // R3 one-bit campaign, R6 intersection
        campaign(1'b0, 8'h25, "R3 R6");
        // R10: pair after found is ignored
        send_pair(8'h11, 8'h13, 1'b0, 1'b0, nb);
        chk("R10 no busy when found", nb, 0);
        check_outputs("R10 after found");
        do_clear();
        chk("R1 clear busy", busy, 0);
        check_outputs("R1 after clear");

        // R4 two-bit campaign
        campaign(1'b1, 8'hc7, "R4 R6");
        do_clear();

        // R7: search two disjoint sets
        do begin
            c1 = $urandom_range(0, 255); d1 = c1 ^ (8'h01 << $urandom_range(0, 7));
            c2 = $urandom_range(0, 255); d2 = c2 ^ (8'h01 << $urandom_range(0, 7));
            s1 = ref_set(c1, d1, 1'b0); s2 = ref_set(c2, d2, 1'b0);
        end while ((s1 & s2) != 0 || s1 == 0 || s2 == 0);
        send_pair(c1, d1, 1'b0, 1'b0, nb);
        chk("R5 first set", cand_count, tb_pop(s1));
        send_pair(c2, d2, 1'b0, 1'b0, nb);
        chk("R7 union", cand_count, tb_pop(s1 | s2));
        check_outputs("R7");
        do_clear();

        // R10: strobe inside a scan is dropped
        c1 = $urandom_range(0, 255);
        send_pair(c1, c1 ^ 8'h08, 1'b0, 1'b1, nb);
        chk("R10 busy length with junk", nb, 257);
        check_outputs("R10 mid-scan strobe");
        do_clear();

        // R11: clear in mid-scan
        @(negedge clk);
        pair_valid = 1'b1; pair_good = 8'h3c; pair_bad = 8'h3d; two_bit_mode = 1'b0;
        @(negedge clk); pair_valid = 1'b0;
        repeat (50) @(negedge clk);
        chk("R11 busy before clear", busy, 1);
        do_clear();
        chk("R11 busy after clear", busy, 0);
        check_outputs("R11 aborted");
        c1 = 8'h9e; d1 = 8'h9e ^ 8'h40;
        send_pair(c1, d1, 1'b0, 1'b0, nb);
        chk("R11 R5 next is first set", cand_count, tb_pop(ref_set(c1, d1, 1'b0)));
        check_outputs("R11 after restart");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule